// File: doc/BRIEF.md
# Host Bus Activity Watchdog

This block guards a register bank against a host that stops talking. A serial bus engine gives it a one-cycle strobe for each completed transaction. A free-running timebase gives it a 1 ms tick. If the host stays silent for too long after it has started talking, the block raises one recovery request. That request is either a pulse that returns selected registers to their defaults, or a pulse that asks for a full hardware reset.

A 2-bit mode code sets both the silence limit and the action. The watchdog is enabled out of reset but stays dormant: it does not count until the first transaction arrives. Every later transaction restarts the count. When the limit is reached, the block fires its pulse and goes dormant again until the host speaks. Changing the mode code restarts the count but leaves the block armed or dormant as it was. The serial protocol engine and the register file sit outside this block.

Top module: `hbw_top`

## Requirements
- R1: While reset is applied and in the cycle after it, `armed_o`, `reg_reset_o` and `hw_reset_o` are all 0.
- R2: While dormant, ticks are ignored and no request pulse fires; a transaction strobe sampled while the mode is not 11 makes `armed_o` read 1 from the next cycle.
- R3: Every transaction restarts the count, so a timeout fires only after a full limit of ticks with no transaction since the last one.
- R4: Mode 00 fires `reg_reset_o` (and never `hw_reset_o`) in the cycle after the LONG_TICKS-th tick sampled since the last transaction.
- R5: Mode 01 fires `hw_reset_o` in the cycle after the LONG_TICKS-th tick sampled since the last transaction.
- R6: Mode 10 fires `hw_reset_o` in the cycle after the SHORT_TICKS-th tick sampled since the last transaction.
- R7: Mode 11 disables the watchdog: any armed state is cleared in the next cycle, transactions do not arm it, and no pulse fires.
- R8: After a timeout the block is dormant (`armed_o` is 0 in the cycle of the pulse) and stays so until the next transaction, whatever the number of ticks.
- R9: A change of the mode code between enabled codes restarts the count from zero and keeps `armed_o` unchanged.
- R10: Each request pulse lasts exactly one cycle, and at most one of the two request outputs is 1 in any cycle.
- R11: A transaction sampled in the same cycle as the tick that would expire the count wins: no pulse fires and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_txn_i | input | 1 | One-cycle strobe per completed host transaction |
| mode_i | input | 2 | 00 register reset/long, 01 hardware reset/long, 10 hardware reset/short, 11 off |
| tick_1ms_i | input | 1 | One-cycle timebase tick, nominally each millisecond |
| reg_reset_o | output | 1 | One-cycle request to restore selected registers to defaults |
| hw_reset_o | output | 1 | One-cycle request for a full hardware reset |
| armed_o | output | 1 | 1 while the watchdog is counting host silence |

## Verification
The bench looks for off-by-one expiry by giving exactly one tick fewer than the limit and then the final tick. A design that counted one tick early or late would fire at the wrong point or not at all. It races a transaction against the expiring tick; a design with the wrong priority would fire a reset while the host is active. It changes the mode part-way through a count. A design that kept the old count would time out early, and one that dropped the armed state would never fire. Random traffic with mode changes and resets is checked cycle by cycle against a reference model, which catches pulses that are doubled, stretched or sent to the wrong output.

// File: rtl/hbw_pkg.sv
// Package: shared mode encoding for the host bus activity watchdog.
// Assumes the 2-bit mode code is sampled directly from a control register.
package hbw_pkg;

    typedef enum logic [1:0] {
        HBW_REGRST_LONG = 2'b00,
        HBW_HWRST_LONG  = 2'b01,
        HBW_HWRST_SHORT = 2'b10,
        HBW_OFF         = 2'b11
    } hbw_mode_e;

    typedef enum logic [1:0] {
        HBW_ACT_NONE = 2'b00,
        HBW_ACT_REG  = 2'b01,
        HBW_ACT_HW   = 2'b10
    } hbw_action_e;

endpackage

// File: rtl/hbw_mode_decode.sv
// Module: hbw_mode_decode
// Turns the mode code into an enable, a tick limit and an action kind.
// Assumes SHORT_TICKS <= LONG_TICKS and both are at least 1.
module hbw_mode_decode
    import hbw_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 160000,
    parameter int unsigned SHORT_TICKS = 40000,
    localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1)
) (
    input  logic [1:0]       mode_i,
    output logic             enable_o,
    output logic [CNT_W-1:0] limit_o,
    output hbw_action_e      action_o
);

    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_TICKS);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_TICKS);

    // Purpose: map each mode code to its limit and action.
    always_comb begin
        enable_o = 1'b1;
        limit_o  = LIM_LONG;
        action_o = HBW_ACT_NONE;
        unique case (hbw_mode_e'(mode_i))
            HBW_REGRST_LONG: begin
                action_o = HBW_ACT_REG;
            end
            HBW_HWRST_LONG: begin
                action_o = HBW_ACT_HW;
            end
            HBW_HWRST_SHORT: begin
                limit_o  = LIM_SHORT;
                action_o = HBW_ACT_HW;
            end
            HBW_OFF: begin
                enable_o = 1'b0;
            end
            default: begin
                enable_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hbw_arm_ctrl.sv
// Module: hbw_arm_ctrl
// Holds the armed/dormant state and spots changes of the mode code.
// Assumes the strobe and expiry inputs are one-cycle wide.
module hbw_arm_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       txn_i,
    input  logic       expire_i,
    input  logic [1:0] mode_i,
    output logic       armed_o,
    output logic       mode_chg_o
);

    logic [1:0] mode_q;
    logic       armed_q;

    // Purpose: remember the previous mode code (reset follows the live code).
    always_ff @(posedge clk) begin
        mode_q <= mode_i;
    end

    // Purpose: arm on a transaction, disarm on expiry or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!enable_i) begin
            armed_q <= 1'b0;
        end else if (txn_i) begin
            armed_q <= 1'b1;
        end else if (expire_i) begin
            armed_q <= 1'b0;
        end
    end

    // Purpose: flag a mode change only after reset has settled mode_q.
    logic started_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
        end else begin
            started_q <= 1'b1;
        end
    end

    assign mode_chg_o = started_q && (mode_i != mode_q);
    assign armed_o    = armed_q;

endmodule

// File: rtl/hbw_timeout_counter.sv
// Module: hbw_timeout_counter
// Counts ticks while armed and flags the tick that reaches the limit.
// Assumes limit_i >= 1; any clear input forces the count to zero.
module hbw_timeout_counter #(
    parameter int unsigned LONG_TICKS = 160000,
    localparam int unsigned CNT_W     = $clog2(LONG_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             armed_i,
    input  logic             enable_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] count_q;
    logic             at_last;
    logic             clear;

    // Purpose: detect the tick that completes the limit.
    always_comb begin
        at_last  = (count_q == (limit_i - CNT_W'(1)));
        expire_o = armed_i && enable_i && tick_i && !restart_i && at_last;
        clear    = restart_i || !armed_i || !enable_i || expire_o;
    end

    // Purpose: tick counter with restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (tick_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hbw_top.sv
// Module: hbw_top
// Host bus activity watchdog: dormant until the first transaction, then
// fires one reset request after a mode-selected run of silent ticks.
// Assumes tick_1ms_i and bus_txn_i are synchronous one-cycle strobes.
module hbw_top
    import hbw_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = 160000,
    parameter int unsigned SHORT_TICKS = 40000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_txn_i,
    input  logic [1:0] mode_i,
    input  logic       tick_1ms_i,
    output logic       reg_reset_o,
    output logic       hw_reset_o,
    output logic       armed_o
);

    localparam int unsigned CNT_W = $clog2(LONG_TICKS + 1);

    logic             enable;
    logic [CNT_W-1:0] limit;
    hbw_action_e      action;
    logic             armed;
    logic             mode_chg;
    logic             expire;
    logic             reg_q;
    logic             hw_q;

    hbw_mode_decode #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_decode (
        .mode_i   (mode_i),
        .enable_o (enable),
        .limit_o  (limit),
        .action_o (action)
    );

    hbw_arm_ctrl u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .txn_i      (bus_txn_i),
        .expire_i   (expire),
        .mode_i     (mode_i),
        .armed_o    (armed),
        .mode_chg_o (mode_chg)
    );

    hbw_timeout_counter #(
        .LONG_TICKS (LONG_TICKS)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_1ms_i),
        .armed_i   (armed),
        .enable_i  (enable),
        .restart_i (bus_txn_i || mode_chg),
        .limit_i   (limit),
        .expire_o  (expire)
    );

    // Purpose: register one request pulse per expiry, steered by the action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= 1'b0;
            hw_q  <= 1'b0;
        end else begin
            reg_q <= expire && (action == HBW_ACT_REG);
            hw_q  <= expire && (action == HBW_ACT_HW);
        end
    end

    assign reg_reset_o = reg_q;
    assign hw_reset_o  = hw_q;
    assign armed_o     = armed;

endmodule

// File: rtl/hbw_checker.sv
// Module: hbw_checker
// Protocol checks on the watchdog ports, bound to every hbw_top instance.
// Assumes synchronous active-low reset on rst_n.
module hbw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_txn_i,
    input logic [1:0] mode_i,
    input logic       reg_reset_o,
    input logic       hw_reset_o,
    input logic       armed_o
);

    a_r10_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_reset_o, hw_reset_o}));

    a_r10_reg_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_reset_o |=> !reg_reset_o);

    a_r10_hw_single: assert property (@(posedge clk) disable iff (!rst_n)
        hw_reset_o |=> !hw_reset_o);

    a_r8_dormant_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_reset_o || hw_reset_o) |-> !armed_o);

    a_r7_off_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |=> !armed_o);

    a_r2_txn_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_txn_i && mode_i != 2'b11) |=> armed_o);

    a_r2_dormant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |=> !(reg_reset_o || hw_reset_o));

    a_r4_reg_only_mode0: assert property (@(posedge clk) disable iff (!rst_n)
        reg_reset_o |-> ($past(mode_i) == 2'b00));

endmodule

bind hbw_top hbw_checker u_hbw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_txn_i   (bus_txn_i),
    .mode_i      (mode_i),
    .reg_reset_o (reg_reset_o),
    .hw_reset_o  (hw_reset_o),
    .armed_o     (armed_o)
);

// File: tb/hbw_top_tb.sv
module hbw_top_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LT = 20;
    localparam int ST = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_txn = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       tick = 1'b0;
    logic       reg_reset, hw_reset, armed;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    // reference model state
    logic       m_armed = 1'b0;
    int         m_cnt = 0;
    logic [1:0] m_mprev = 2'b00;
    logic       m_started = 1'b0;
    logic       m_reg = 1'b0, m_hw = 1'b0;

    always #2.5 clk = ~clk;

    hbw_top #(.LONG_TICKS(LT), .SHORT_TICKS(ST)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_txn_i   (bus_txn),
        .mode_i      (mode),
        .tick_1ms_i  (tick),
        .reg_reset_o (reg_reset),
        .hw_reset_o  (hw_reset),
        .armed_o     (armed)
    );

    function automatic int limit_of(input logic [1:0] md);
        return (md == 2'b10) ? ST : LT;
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {armed,reg,hw} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model of one clock edge, written from the requirements.
    task automatic model_edge(input logic txn, input logic [1:0] md, input logic tk);
        logic en, chg, ex;
        if (!rst_n) begin
            m_armed = 0; m_cnt = 0; m_reg = 0; m_hw = 0; m_started = 0;
        end else begin
            en  = (md != 2'b11);
            chg = m_started && (md != m_mprev);
            ex  = m_armed && en && tk && !txn && !chg && (m_cnt == limit_of(md) - 1);
            m_reg = ex && (md == 2'b00);
            m_hw  = ex && (md != 2'b00);
            if (txn || chg || !en || !m_armed || ex) m_cnt = 0;
            else if (tk) m_cnt++;
            if (!en) m_armed = 0;
            else if (txn) m_armed = 1;
            else if (ex) m_armed = 0;
            m_started = 1;
        end
        m_mprev = md;
    endtask

    task automatic step(input logic txn, input logic [1:0] md, input logic tk);
        bus_txn = txn; mode = md; tick = tk;
        @(posedge clk); #1;
        model_edge(txn, md, tk);
        chk(cur_req, {armed, reg_reset, hw_reset}, {m_armed, m_reg, m_hw});
        @(negedge clk);
    endtask

    task automatic ticks(input int n, input logic [1:0] md);
        for (int i = 0; i < n; i++) step(1'b0, md, 1'b1);
    endtask

    task automatic do_reset(input logic [1:0] md);
        rst_n = 1'b0;
        step(1'b0, md, 1'b1);
        step(1'b0, md, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic expect_now(input string req, input logic [2:0] exp);
        chk(req, {armed, reg_reset, hw_reset}, exp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd12345));
        @(negedge clk);
        cur_req = "R1";
        do_reset(2'b00);
        expect_now("R1", 3'b000);
        step(1'b0, 2'b00, 1'b0);
        expect_now("R1", 3'b000);

        // R2: dormant ignores ticks
        cur_req = "R2";
        ticks(3 * LT, 2'b00);
        expect_now("R2", 3'b000);
        step(1'b1, 2'b00, 1'b0);
        expect_now("R2", 3'b100);

        // R4: register reset after exactly LT ticks
        cur_req = "R4";
        ticks(LT - 1, 2'b00);
        expect_now("R4", 3'b100);
        ticks(1, 2'b00);
        expect_now("R4", 3'b010);
        // R10: pulse lasts one cycle
        step(1'b0, 2'b00, 1'b0);
        expect_now("R10", 3'b000);

        // R8: dormant after expiry
        cur_req = "R8";
        ticks(2 * LT, 2'b00);
        expect_now("R8", 3'b000);

        // R5: hardware reset, long limit
        cur_req = "R5";
        step(1'b1, 2'b01, 1'b0);
        ticks(LT - 1, 2'b01);
        expect_now("R5", 3'b100);
        ticks(1, 2'b01);
        expect_now("R5", 3'b001);

        // R6: hardware reset, short limit
        cur_req = "R6";
        step(1'b1, 2'b10, 1'b0);
        ticks(ST - 1, 2'b10);
        expect_now("R6", 3'b100);
        ticks(1, 2'b10);
        expect_now("R6", 3'b001);

        // R3: a transaction restarts the count
        cur_req = "R3";
        step(1'b1, 2'b00, 1'b0);
        ticks(LT - 2, 2'b00);
        step(1'b1, 2'b00, 1'b0);
        ticks(LT - 1, 2'b00);
        expect_now("R3", 3'b100);
        ticks(1, 2'b00);
        expect_now("R3", 3'b010);

        // R9: mode change restarts the count and keeps armed
        cur_req = "R9";
        step(1'b1, 2'b00, 1'b0);
        ticks(LT - 2, 2'b00);
        step(1'b0, 2'b01, 1'b0);
        expect_now("R9", 3'b100);
        ticks(LT - 1, 2'b01);
        expect_now("R9", 3'b100);
        ticks(1, 2'b01);
        expect_now("R9", 3'b001);

        // R11: transaction beats the expiring tick
        cur_req = "R11";
        step(1'b1, 2'b10, 1'b0);
        ticks(ST - 1, 2'b10);
        step(1'b1, 2'b10, 1'b1);
        expect_now("R11", 3'b100);
        ticks(ST, 2'b10);
        expect_now("R11", 3'b001);

        // R7: off mode disarms and refuses to arm
        cur_req = "R7";
        step(1'b1, 2'b00, 1'b0);
        step(1'b0, 2'b11, 1'b0);
        expect_now("R7", 3'b000);
        step(1'b1, 2'b11, 1'b1);
        ticks(2 * LT, 2'b11);
        expect_now("R7", 3'b000);

        // Random traffic checked against the model (R3, R9, R10)
        cur_req = "R10";
        for (int i = 0; i < 20000; i++) begin
            logic [1:0] md;
            md = mode;
            if ($urandom_range(0, 399) == 0) md = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 4999) == 0) do_reset(md);
            step($urandom_range(0, 149) == 0, md, $urandom_range(0, 3) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule